// File: doc/BRIEF.md
# Software Interrupt Request Register

This block is a single memory-mapped word through which software posts interrupt requests to itself at priority levels 1 to 7. Each level has its own request flag in the upper byte of the word. The lower byte is read-only. It always shows the highest pending level as a double-coded value: the level number appears in bits 7:5 and again in bits 3:1. Software can therefore use that byte directly as a priority value, or shift it to get a table index.

A small request state machine compares the highest pending level with the processor's current priority. It raises an interrupt request, carrying that level, only while the pending level is strictly above the priority. The machine has three states:

- ST_QUIET: no request is driven.
- ST_ASSERT: a request is driven.
- ST_ACKED: a one-cycle gap after an acknowledge.

Its transitions are:

- QUIET→ASSERT when a pending level exceeds the priority.
- ASSERT→ACKED on acknowledge.
- ASSERT→QUIET when no pending level exceeds the priority.
- ACKED→QUIET unconditionally.

An acknowledge never clears a request flag. The handler clears its own flag with a write.

Top module: `swirq_reg`

## Requirements
- R1: Reset clears every request flag, so that rd_data reads 0 and irq_req is low.
- R2: A write with wr_be[1] set loads wr_data[8+n] into the flag of level n, for n = 1..7. Bit 8 always reads 0.
- R3: rd_data[7:0] equals 34 (octal 042) times the highest pending level. That places the level in bits 7:5 and 3:1, with bits 4 and 0 at 0. The byte reads 0 when no flag is set.
- R4: When several flags are set, the highest level is reported, and the lower flags stay set and keep reading back.
- R5: A write with only wr_be[0] set changes nothing; rd_data stays the same.
- R6: irq_req is high only while the highest pending level is above cpu_pri, and irq_lvl then equals that level. Otherwise irq_lvl is 0. Raising cpu_pri to 7 drops irq_req in the same cycle.
- R7: A word write that clears flags updates rd_data after the write edge, showing the next highest remaining level or 0.
- R8: irq_ack leaves every flag unchanged. irq_req is low for the two cycles after the acknowledge edge and is then raised again if the level is still above cpu_pri.
- R9: A write that creates a qualifying request raises irq_req at the second rising edge after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe (address already decoded) |
| wr_be | input | 2 | Byte enables: [1] upper byte, [0] lower byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register read value |
| cpu_pri | input | 3 | Current processor priority |
| irq_req | output | 1 | Interrupt request toward the processor |
| irq_lvl | output | 3 | Level of the driven request, 0 when idle |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
The assertions assume three things about the inputs:

- irq_ack is a single-cycle pulse, given only while irq_req is high.
- No write coincides with an acknowledge.
- cpu_pri is an ordinary registered value.

The bench keeps within these assumptions. It holds irq_ack low except for one directed pulse, and it issues that pulse with no write present and only after it has seen a request. Writes and priority changes are applied one at a time at falling edges, and each is followed by two idle cycles before sampling. This keeps the acknowledge gap and the write-to-request latency apart.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

    localparam int NUM_LVL = 7;
    localparam int LVL_W   = 3;
    localparam int DATA_W  = 16;
    localparam int FLAG_LSB = 9;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_ASSERT = 2'd1,
        ST_ACKED  = 2'd2
    } req_state_e;

    // Double-coded level byte: level in [7:5] and [3:1], zeros elsewhere
    function automatic logic [7:0] code_byte(input logic [LVL_W-1:0] lvl);
        return {lvl, 1'b0, lvl, 1'b0};
    endfunction

endpackage

// File: rtl/swirq_bank.sv
module swirq_bank
    import swirq_pkg::*;
#(
    parameter int N = NUM_LVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] din,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (load)
                flags[g] <= din[g];
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags)) else $error("flags moved without load"); // R5

endmodule

// File: rtl/swirq_prio_enc.sv
module swirq_prio_enc
    import swirq_pkg::*;
#(
    parameter int N = NUM_LVL,
    parameter int W = LVL_W
) (
    input  logic [N-1:0] flags,
    output logic [W-1:0] top
);

    always_comb begin
        top = '0;
        for (int i = 1; i <= N; i++) begin
            if (flags[i-1])
                top = W'(i);
        end
    end

endmodule

// File: rtl/swirq_fsm.sv
module swirq_fsm
    import swirq_pkg::*;
#(
    parameter int W = LVL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] top,
    input  logic [W-1:0] cpu_pri,
    input  logic         irq_ack,
    output logic         irq_req,
    output logic [W-1:0] irq_lvl
);

    req_state_e state, state_nx;
    logic       above;

    assign above = (top > cpu_pri);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:  if (above) state_nx = ST_ASSERT;
            ST_ASSERT: begin
                if (irq_ack)     state_nx = ST_ACKED;
                else if (!above) state_nx = ST_QUIET;
            end
            ST_ACKED:  state_nx = ST_QUIET;
            default:   state_nx = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_QUIET;
        else
            state <= state_nx;
    end

    always_comb begin
        irq_req = (state == ST_ASSERT) && above;
        irq_lvl = irq_req ? top : '0;
    end

    AST_REQ_ABOVE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > cpu_pri)) else $error("request not above priority"); // R6
    AST_LVL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_lvl == '0)) else $error("level driven while idle"); // R6
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !irq_req) else $error("request after ack"); // R8
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACKED) |=> (state == ST_QUIET)) else $error("ack gap too short"); // R8

endmodule

// File: rtl/swirq_reg.sv
module swirq_reg
    import swirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  cpu_pri,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_lvl,
    input  logic              irq_ack
);

    logic [NUM_LVL-1:0] flags;
    logic [LVL_W-1:0]   top;
    logic               hi_load;
    logic               unused_low;

    assign hi_load    = wr_en && wr_be[1];
    assign unused_low = ^{wr_be[0], wr_data[FLAG_LSB-1:0]};

    swirq_bank #(.N(NUM_LVL)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hi_load),
        .din   (wr_data[FLAG_LSB +: NUM_LVL]),
        .flags (flags)
    );

    swirq_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_enc (
        .flags (flags),
        .top   (top)
    );

    swirq_fsm #(.W(LVL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .top     (top),
        .cpu_pri (cpu_pri),
        .irq_ack (irq_ack),
        .irq_req (irq_req),
        .irq_lvl (irq_lvl)
    );

    assign rd_data = {flags, 1'b0, code_byte(top)};

    AST_ACK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wr_en) |=> $stable(rd_data[DATA_W-1:8])) else $error("ack touched flags"); // R8
    AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b01) |=> $stable(rd_data)) else $error("low byte write took effect"); // R5
    AST_CODE_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[8] == 1'b0) && (rd_data[4] == 1'b0) && (rd_data[0] == 1'b0)) else $error("spare bit set"); // R3

endmodule

// File: tb/tb_swirq_reg.sv
`timescale 1ns/1ps
module tb_swirq_reg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [2:0]  cpu_pri;
    logic        irq_req;
    logic [2:0]  irq_lvl;
    logic        irq_ack;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    swirq_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .cpu_pri(cpu_pri),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_ack(irq_ack)
    );

    // {be, data, pri, exp_rd, exp_irq, exp_lvl}
    localparam int NV = 9;
    localparam logic [40:0] VEC [NV] = '{
        {2'b10, 16'h0200, 3'd7, 16'h0222, 1'b0, 3'd0},  // R2 R3 level 1 under pri 7
        {2'b10, 16'h0A00, 3'd7, 16'h0A66, 1'b0, 3'd0},  // R4 levels 1+3, 3 reported
        {2'b00, 16'h0000, 3'd2, 16'h0A66, 1'b1, 3'd3},  // R6 pri drops below 3
        {2'b11, 16'h0200, 3'd2, 16'h0222, 1'b0, 3'd0},  // R7 clear 3, 1 not above 2
        {2'b00, 16'h0000, 3'd0, 16'h0222, 1'b1, 3'd1},  // R6 level 1 above pri 0
        {2'b01, 16'hFFFF, 3'd0, 16'h0222, 1'b1, 3'd1},  // R5 low byte write ignored
        {2'b11, 16'hFE00, 3'd6, 16'hFEEE, 1'b1, 3'd7},  // R3 all levels, 7 reported
        {2'b11, 16'h0100, 3'd0, 16'h0000, 1'b0, 3'd0},  // R2 R7 bit 8 only: all clear
        {2'b10, 16'h5000, 3'd3, 16'h50CC, 1'b1, 3'd6}   // R4 levels 4+6
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = (be != 2'b00);
        wr_be = be;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_be = 2'b00;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
        cpu_pri = 3'd7; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset rd", rd_data, 16'h0000);
        chk("R1 reset irq", {15'd0, irq_req}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cpu_pri = VEC[i][22:20];
            do_write(VEC[i][40:39], VEC[i][38:23]);
            @(negedge clk);
            chk($sformatf("vec%0d R3 rd", i), rd_data, VEC[i][19:4]);
            chk($sformatf("vec%0d R6 irq", i), {12'd0, irq_req, irq_lvl}, {12'd0, VEC[i][3:0]});
        end

        // R9: latency from write to request
        do_write(2'b11, 16'h0000);
        cpu_pri = 3'd0;
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h0800;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
        chk("R9 irq low after one edge", {15'd0, irq_req}, 16'd0);
        chk("R7 rd after write edge", rd_data, 16'h0866);
        @(negedge clk);
        chk("R9 irq high after two edges", {12'd0, irq_req, irq_lvl}, 16'h000B);

        // R6: raising pri to 7 drops request in same cycle
        cpu_pri = 3'd7;
        #0.5;
        chk("R6 pri 7 holds off", {15'd0, irq_req}, 16'd0);
        @(negedge clk);
        cpu_pri = 3'd0;
        repeat (2) @(negedge clk);
        chk("R6 request back", {15'd0, irq_req}, 16'd1);

        // R8: acknowledge
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R8 irq low after ack", {15'd0, irq_req}, 16'd0);
        chk("R8 flags kept", rd_data, 16'h0866);
        @(negedge clk);
        chk("R8 irq low second cycle", {15'd0, irq_req}, 16'd0);
        @(negedge clk);
        chk("R8 irq re-raised", {12'd0, irq_req, irq_lvl}, 16'h000B);

        // R1: reset mid operation
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset rd", rd_data, 16'h0000);
        chk("R1 mid reset irq", {15'd0, irq_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule